// File: doc/BRIEF.md
# Six-Channel Serial ADC Host Sequencer

This block drives a six-channel serial analog-to-digital converter from the host side. On an acquisition command it raises a convert strobe, which makes the converter sample all of its inputs on the strobe's rising edge. It then runs a divided serial clock for exactly as many 16-bit read slots as channels were requested. From each slot it keeps the last 14 bits, most significant bit first, and presents each result as a one-cycle valid word tagged with its channel index.

Power control uses no serial clock at all. A nap command sends two convert pulses, a sleep command sends four and a wake command sends one, with the serial clock held low throughout. A busy output covers every command from the first convert pulse to the end of its last pulse or slot. A command that arrives while busy is high is dropped. The serial clock is the system clock divided by `SCK_DIV`. Incoming data is captured on the system clock edge at which the serial clock goes high.

Top module: `adc_seq_host`

## Requirements
- R1: After reset `adc_conv`, `adc_sck`, `busy` and `res_valid` are all low.
- R2: An acquisition (`cmd_op` = 2'b00) produces exactly one convert pulse, and `adc_sck` stays low while `adc_conv` is high; `busy` and `adc_conv` rise in the same cycle.
- R3: An acquisition runs `adc_sck` for 16 rising edges per channel; `cmd_nch` values 1 to 6 are used as given, 0 is taken as 1 and values above 6 are taken as 6.
- R4: In each 16-bit slot the first two bits are dropped and the next 14 bits, first received in bit 13, form the word; `res_valid` is high for exactly one cycle per slot, with `res_ch` counting 0, 1, 2, ... in slot order.
- R5: For an acquisition of N channels `busy` is high for exactly `PULSE_HI + PULSE_LO + N*16*SCK_DIV` system clocks; it is low whenever the block is idle, and `res_valid` only occurs while it is high.
- R6: A nap command (`cmd_op` = 2'b01) produces exactly two convert pulses with `adc_sck` low throughout and `busy` high for `2*(PULSE_HI+PULSE_LO)` clocks.
- R7: A sleep command (`cmd_op` = 2'b10) produces exactly four convert pulses with `adc_sck` low throughout and `busy` high for `4*(PULSE_HI+PULSE_LO)` clocks.
- R8: A wake command (`cmd_op` = 2'b11) produces exactly one convert pulse with `adc_sck` low throughout and `busy` high for `PULSE_HI+PULSE_LO` clocks.
- R9: Every convert pulse is high for exactly `PULSE_HI` clocks, and consecutive pulses of one command are separated by exactly `PULSE_LO` low clocks.
- R10: A command presented while `busy` is high is ignored: it adds no convert pulse, no word and no busy time.
- R11: While running, `adc_sck` has period `SCK_DIV` clocks, high for `SCK_DIV/2` and low for at least `SCK_DIV/2` (`SCK_DIV` even, at least 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | 00 acquire, 01 nap, 10 sleep, 11 wake |
| cmd_nch | input | 3 | Number of channels to read for an acquisition |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_conv | output | 1 | Convert strobe to the converter |
| adc_sck | output | 1 | Serial clock to the converter |
| busy | output | 1 | Command in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_ch | output | 3 | Channel index of the result |
| res_data | output | 14 | Result word |

## Verification
The pulse-width and clock-phase properties assume that the block leaves the idle state only through an accepted command. They also assume that the converter model changes `adc_sdo` only shortly after a rising serial clock edge, never on a system clock edge. The bench drives every command input and the model's data a nanosecond or more after the edges that would sample them, and it sets each command's data fields at the same time as `cmd_valid`. The commands sent during busy periods are sent mid-frame, so the ignore path is hit at a point where a wrongly accepted command would visibly add pulses or busy time.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int MAX_CH = 6;
    localparam int CH_W   = 3;
    localparam int RES_W  = 14;
    localparam int SLOT_W = 16;
    localparam int LEAD_W = 2;
    localparam int PCNT_W = 3;

    typedef enum logic [1:0] {
        OP_ACQ   = 2'b00,
        OP_NAP   = 2'b01,
        OP_SLEEP = 2'b10,
        OP_WAKE  = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TRAIN,
        ST_FRAME
    } seq_state_e;

    typedef struct packed {
        logic             vld;
        logic [CH_W-1:0]  ch;
        logic [RES_W-1:0] data;
    } word_t;

    // Number of convert pulses each command needs.
    function automatic logic [PCNT_W-1:0] pulses_for(cmd_op_e op);
        case (op)
            OP_NAP:   return PCNT_W'(2);
            OP_SLEEP: return PCNT_W'(4);
            default:  return PCNT_W'(1);
        endcase
    endfunction

    // Index of the last slot, with the channel request clamped to 1..MAX_CH.
    function automatic logic [CH_W-1:0] last_slot_of(logic [CH_W-1:0] req);
        if (req == '0)
            return '0;
        else if (req > CH_W'(MAX_CH))
            return CH_W'(MAX_CH - 1);
        else
            return req - CH_W'(1);
    endfunction

endpackage

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic sck,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int HALF = DIV / 2;
    localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] ph;
    logic          sck_q;

    assign rise_stb = en && (ph == PW'(HALF - 1));
    assign fall_stb = en && (ph == PW'(DIV - 1));
    assign sck      = sck_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph    <= '0;
            sck_q <= 1'b0;
        end else begin
            ph <= (ph == PW'(DIV - 1)) ? '0 : ph + PW'(1);
            if (rise_stb)
                sck_q <= 1'b1;
            else if (fall_stb)
                sck_q <= 1'b0;
        end
    end
endmodule

// File: rtl/adc_conv_pulser.sv
module adc_conv_pulser #(
    parameter int HI    = 2,
    parameter int LO    = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             conv,
    output logic             done
);
    localparam int PER = HI + LO;
    localparam int PW  = $clog2(PER + 1);

    logic             active;
    logic [PW-1:0]    ph;
    logic [CNT_W-1:0] left;
    logic             conv_q;

    assign conv = conv_q;
    assign done = active && (ph == PW'(PER - 1)) && (left == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            ph     <= '0;
            left   <= '0;
            conv_q <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            ph     <= '0;
            left   <= count;
            conv_q <= 1'b1;
        end else if (active) begin
            if (ph == PW'(PER - 1)) begin
                ph <= '0;
                if (left == CNT_W'(1)) begin
                    active <= 1'b0;
                end else begin
                    left   <= left - CNT_W'(1);
                    conv_q <= 1'b1;
                end
            end else begin
                ph <= ph + PW'(1);
                if (ph == PW'(HI - 1))
                    conv_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/adc_slot_deser.sv
module adc_slot_deser
    import adc_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            bit_stb,
    input  logic            sdo,
    input  logic [CH_W-1:0] last_slot,
    output word_t           word,
    output logic            all_done
);
    localparam int BW = $clog2(SLOT_W);

    logic [BW-1:0]    bit_pos;
    logic [CH_W-1:0]  slot;
    logic [RES_W-1:0] shreg;
    logic [RES_W-1:0] next_sh;

    assign next_sh = {shreg[RES_W-2:0], sdo};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            bit_pos  <= '0;
            slot     <= '0;
            shreg    <= '0;
            all_done <= 1'b0;
            word     <= '0;
        end else begin
            word.vld <= 1'b0;
            if (bit_stb) begin
                if (bit_pos >= BW'(LEAD_W))
                    shreg <= next_sh;
                if (bit_pos == BW'(SLOT_W - 1)) begin
                    bit_pos   <= '0;
                    slot      <= slot + CH_W'(1);
                    word.vld  <= 1'b1;
                    word.ch   <= slot;
                    word.data <= next_sh;
                    if (slot == last_slot)
                        all_done <= 1'b1;
                end else begin
                    bit_pos <= bit_pos + BW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
    import adc_seq_pkg::*;
#(
    parameter int SCK_DIV  = 4,
    parameter int PULSE_HI = 2,
    parameter int PULSE_LO = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [CH_W-1:0]  cmd_nch,
    input  logic             adc_sdo,
    output logic             adc_conv,
    output logic             adc_sck,
    output logic             busy,
    output logic             res_valid,
    output logic [CH_W-1:0]  res_ch,
    output logic [RES_W-1:0] res_data
);
    seq_state_e      state;
    cmd_op_e         op_q;
    logic [CH_W-1:0] last_slot_q;
    logic            accept;
    logic            train_done;
    logic            sck_rise;
    logic            sck_fall;
    logic            frame_done;
    word_t           word;

    assign accept = cmd_valid && (state == ST_IDLE);
    assign busy   = (state != ST_IDLE);

    adc_conv_pulser #(
        .HI    (PULSE_HI),
        .LO    (PULSE_LO),
        .CNT_W (PCNT_W)
    ) i_pulser (
        .clk   (clk),
        .rst   (rst),
        .start (accept),
        .count (pulses_for(cmd_op_e'(cmd_op))),
        .conv  (adc_conv),
        .done  (train_done)
    );

    adc_sck_gen #(
        .DIV (SCK_DIV)
    ) i_sck (
        .clk      (clk),
        .rst      (rst),
        .en       (state == ST_FRAME),
        .sck      (adc_sck),
        .rise_stb (sck_rise),
        .fall_stb (sck_fall)
    );

    adc_slot_deser i_deser (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .bit_stb   (sck_rise),
        .sdo       (adc_sdo),
        .last_slot (last_slot_q),
        .word      (word),
        .all_done  (frame_done)
    );

    assign res_valid = word.vld;
    assign res_ch    = word.ch;
    assign res_data  = word.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            op_q        <= OP_ACQ;
            last_slot_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state       <= ST_TRAIN;
                        op_q        <= cmd_op_e'(cmd_op);
                        last_slot_q <= last_slot_of(cmd_nch);
                    end
                end
                ST_TRAIN: begin
                    if (train_done)
                        state <= (op_q == OP_ACQ) ? ST_FRAME : ST_IDLE;
                end
                ST_FRAME: begin
                    if (sck_fall && frame_done)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

module adc_seq_host_chk #(
    parameter int SCK_DIV  = 4,
    parameter int PULSE_HI = 2,
    parameter int PULSE_LO = 2
) (
    input logic clk,
    input logic rst,
    input logic adc_conv,
    input logic adc_sck,
    input logic busy,
    input logic res_valid
);
    logic [7:0] conv_hi, conv_lo, sck_hi, sck_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            conv_hi <= '0;
            conv_lo <= '0;
            sck_hi  <= '0;
            sck_lo  <= '0;
        end else begin
            conv_hi <= adc_conv ? ((conv_hi == 8'hFF) ? conv_hi : conv_hi + 8'd1) : 8'd0;
            conv_lo <= adc_conv ? 8'd0 : ((conv_lo == 8'hFF) ? conv_lo : conv_lo + 8'd1);
            sck_hi  <= adc_sck ? ((sck_hi == 8'hFF) ? sck_hi : sck_hi + 8'd1) : 8'd0;
            sck_lo  <= adc_sck ? 8'd0 : ((sck_lo == 8'hFF) ? sck_lo : sck_lo + 8'd1);
        end
    end

    p_sck_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        adc_conv |-> !adc_sck);
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $rose(adc_conv));
    p_single_valid_r4: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!adc_conv && !adc_sck && !res_valid));
    p_pulse_width_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_conv) |-> (conv_hi == 8'(PULSE_HI)));
    p_pulse_gap_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(adc_conv) && $past(busy)) |-> (conv_lo == 8'(PULSE_LO)));
    p_sck_high_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sck) |-> (sck_hi == 8'(SCK_DIV / 2)));
    p_sck_low_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sck) |-> (sck_lo >= 8'(SCK_DIV / 2)));
endmodule

bind adc_seq_host adc_seq_host_chk #(
    .SCK_DIV  (SCK_DIV),
    .PULSE_HI (PULSE_HI),
    .PULSE_LO (PULSE_LO)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .adc_conv  (adc_conv),
    .adc_sck   (adc_sck),
    .busy      (busy),
    .res_valid (res_valid)
);

// File: tb/test_adc_seq_host.sv
`timescale 1ns/1ps
module test_adc_seq_host;
    localparam int DIV = 4;
    localparam int PH  = 2;
    localparam int PL  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [2:0]  cmd_nch = 3'd0;
    logic        adc_sdo = 1'b0;
    logic        adc_conv, adc_sck, busy, res_valid;
    logic [2:0]  res_ch;
    logic [13:0] res_data;

    always #2.5 clk = ~clk;

    adc_seq_host #(.SCK_DIV(DIV), .PULSE_HI(PH), .PULSE_LO(PL)) i_adc_seq_host (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_nch(cmd_nch), .adc_sdo(adc_sdo), .adc_conv(adc_conv),
        .adc_sck(adc_sck), .busy(busy), .res_valid(res_valid),
        .res_ch(res_ch), .res_data(res_data));

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // Converter model
    int seed = 0;
    int k    = 0;

    function automatic logic [13:0] word_of(int s, int ch);
        return 14'((s * 977 + ch * 1531 + s * ch * 37) ^ (s << 3));
    endfunction

    function automatic logic bit_at(int s, int idx);
        int slot = idx / 16;
        int pos  = idx % 16;
        logic [13:0] w = word_of(s, slot);
        if (pos < 2)
            return (pos == 0) ? 1'b1 : slot[0];
        return w[13 - (pos - 2)];
    endfunction

    always @(posedge adc_conv) begin
        k = 0;
        #1 adc_sdo = bit_at(seed, 0);
    end
    always @(posedge adc_sck) begin
        k = k + 1;
        #1 adc_sdo = bit_at(seed, k);
    end

    // Monitor
    int conv_rises, sck_rises, busy_cyc, sck_hi_cyc, overlap, wcnt;
    logic prev_conv = 1'b0, prev_sck = 1'b0;
    logic [13:0] got_data [0:15];
    logic [2:0]  got_ch   [0:15];

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (adc_conv && !prev_conv) conv_rises++;
            if (adc_sck && !prev_sck)   sck_rises++;
            if (busy)                   busy_cyc++;
            if (adc_sck)                sck_hi_cyc++;
            if (adc_sck && adc_conv)    overlap++;
            if (res_valid) begin
                if (wcnt < 16) begin
                    got_data[wcnt] = res_data;
                    got_ch[wcnt]   = res_ch;
                end
                wcnt++;
            end
        end
        prev_conv = adc_conv;
        prev_sck  = adc_sck;
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        conv_rises = 0; sck_rises = 0; busy_cyc = 0;
        sck_hi_cyc = 0; overlap = 0; wcnt = 0;
    endtask

    task automatic send(input logic [1:0] op, input logic [2:0] nch);
        cmd_op    = op;
        cmd_nch   = nch;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!adc_conv && !adc_sck && !busy && !res_valid, "R1 outputs low in reset",
              {adc_conv, adc_sck, busy, res_valid}, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(!adc_conv && !adc_sck && !busy && !res_valid, "R1 outputs low after reset",
              {adc_conv, adc_sck, busy, res_valid}, 0);
    endtask

    task automatic t_acquire(input logic [2:0] req, input int nexp, input int s);
        seed = s;
        clear_mon();
        send(2'b00, req);
        wait_idle();
        check(conv_rises == 1, "R2 one convert pulse", conv_rises, 1);
        check(overlap == 0, "R2 sck low while conv high", overlap, 0);
        check(sck_rises == nexp * 16, "R3 sck edges", sck_rises, nexp * 16);
        check(busy_cyc == PH + PL + nexp * 16 * DIV, "R5 busy length", busy_cyc,
              PH + PL + nexp * 16 * DIV);
        check(sck_hi_cyc == nexp * 16 * (DIV / 2), "R11 sck high time", sck_hi_cyc,
              nexp * 16 * (DIV / 2));
        check(wcnt == nexp, "R4 word count", wcnt, nexp);
        for (int i = 0; i < nexp && i < wcnt; i++) begin
            check(got_ch[i] == 3'(i), "R4 channel order", int'(got_ch[i]), i);
            check(got_data[i] == word_of(s, i), "R4 word data", int'(got_data[i]),
                  int'(word_of(s, i)));
        end
    endtask

    task automatic t_power(input logic [1:0] op, input int npulse, input string req);
        clear_mon();
        send(op, 3'd6);
        wait_idle();
        check(conv_rises == npulse, {req, " pulse count"}, conv_rises, npulse);
        check(sck_hi_cyc == 0, {req, " sck static"}, sck_hi_cyc, 0);
        check(busy_cyc == npulse * (PH + PL), {req, " busy length"}, busy_cyc,
              npulse * (PH + PL));
        check(wcnt == 0, {req, " no words"}, wcnt, 0);
    endtask

    task automatic t_ignore();
        int base;
        seed = 5;
        clear_mon();
        send(2'b00, 3'd2);
        repeat (20) @(negedge clk);
        send(2'b10, 3'd6);
        repeat (30) @(negedge clk);
        send(2'b00, 3'd6);
        wait_idle();
        base = busy_cyc;
        repeat (10) @(negedge clk);
        check(conv_rises == 1, "R10 no extra pulses", conv_rises, 1);
        check(base == PH + PL + 2 * 16 * DIV, "R10 busy unchanged", base,
              PH + PL + 2 * 16 * DIV);
        check(busy_cyc == base, "R10 no restart afterwards", busy_cyc, base);
        check(wcnt == 2, "R10 word count", wcnt, 2);
    endtask

    initial begin
        t_reset();
        t_acquire(3'd1, 1, 11);
        t_acquire(3'd3, 3, 42);
        t_acquire(3'd6, 6, 1234);
        t_acquire(3'd0, 1, 7);    // R3 zero request clamps to one
        t_acquire(3'd7, 6, 99);   // R3 oversize request clamps to six
        t_power(2'b01, 2, "R6 nap");
        t_power(2'b10, 4, "R7 sleep");
        t_power(2'b11, 1, "R8 wake");
        t_acquire(3'd2, 2, 300);  // R9 train then acquisition
        t_ignore();
        finish_run();
    end
endmodule